// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block holds the small control register that picks what starts an analog-to-digital conversion when auto-triggering is on. The register has an alignment bit, two spare storage bits and a 3-bit source select. The selected event flag passes through a multiplexer and an edge detector. A rising edge on the muxed flag gives a one-cycle start pulse to the conversion sequencer. The pulse is only sent when the auto-trigger enable and the converter enable are both high.

Because detection works on the muxed signal, rewriting the select can itself make a trigger: moving from a source whose flag is low to one whose flag is high looks like a rising edge. The one exception is a switch into free-running mode. In that mode the converter's own completion flag is the source, so each completed conversion starts the next one. A switch into free-running mode is held quiet even when the completion flag is already high. The conversion itself and the clearing of flags are handled elsewhere.

Top module: `adc_trig_sel`

## Requirements
- R1: After reset, the read byte is 0x00, the alignment output is 0 and no start pulse appears.
- R2: A write stores data bits 5..0. Reading returns those bits in the same positions, and bits 7..6 always read 0. Bits 5 and 3 have no function and only keep what was written.
- R3: The alignment output equals register bit 4 from the cycle after the write that sets it, with or without a conversion running.
- R4: Select field bits 2..0 pick the trigger source: 0 = conversion-complete flag (free running), 1 = comparator flag, 2 = external interrupt 0 flag, 3 = timer 0 compare-match-A flag, 4 = timer 0 overflow flag. Flags that are not selected never cause a start.
- R5: A start pulse is only produced while both auto_en_i and adc_en_i are 1.
- R6: A rising edge of the selected signal gives exactly one start pulse, in the cycle the signal is first high. A signal that stays high gives no further pulse.
- R7: A write that changes the select from a source whose flag is low to one whose flag is high produces a start pulse in the cycle after the write.
- R8: In the cycle after a write that changes the select from a non-zero code to 0, no start pulse is produced, even when the conversion-complete flag is high.
- R9: In free-running mode, a rising edge of the conversion-complete flag produces a start pulse.
- R10: Select codes 5, 6 and 7 act as a source that is always low and never produce a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| left_adj_o | output | 1 | Result alignment control (1 = left adjusted) |
| conv_done_i | input | 1 | Conversion-complete flag |
| cmp_flag_i | input | 1 | Analog comparator flag |
| ext0_flag_i | input | 1 | External interrupt 0 flag |
| tc0_cmpa_flag_i | input | 1 | Timer 0 compare-match-A flag |
| tc0_ovf_flag_i | input | 1 | Timer 0 overflow flag |
| auto_en_i | input | 1 | Auto-trigger enable |
| adc_en_i | input | 1 | Converter enable |
| start_o | output | 1 | One-cycle conversion start pulse |

## Verification
A register write and a flag edge can happen in the same cycle, and the pulse depends on both. When a write moves the select while the old or new flag changes, the start pulse is decided by the mix of the stored previous value and the new source. The bench forces this by writing select codes while flags are held high or rising, including a switch into free-running mode with the completion flag high. A behavioural model that tracks the previous muxed value, and forces it high on a switch into free-running mode, predicts the pulse and the read byte. That prediction is compared with the outputs on every clock.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 3;
  localparam int LADJ_B  = 4;
  localparam int STORE_W = 6;
  localparam int N_SRC   = 5;

  typedef enum logic [SEL_W-1:0] {
    SRC_FREE     = 3'd0,
    SRC_CMP      = 3'd1,
    SRC_EXT0     = 3'd2,
    SRC_TC0_CMPA = 3'd3,
    SRC_TC0_OVF  = 3'd4
  } trig_src_e;
endpackage

// File: rtl/adc_trig_reg.sv
module adc_trig_reg
  import adc_trig_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              left_adj_o,
  output logic              fr_switch_o
);
  logic [STORE_W-1:0] store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      store_q <= '0;
    else if (wr_en_i) store_q <= wr_data_i[STORE_W-1:0];
  end

  assign rd_data_o   = {{(DATA_W-STORE_W){1'b0}}, store_q};
  assign sel_o       = store_q[SEL_W-1:0];
  assign left_adj_o  = store_q[LADJ_B];
  // a write moving the select into free-running mode
  assign fr_switch_o = wr_en_i && (wr_data_i[SEL_W-1:0] == SRC_FREE) && (sel_o != SRC_FREE);

  p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[STORE_W-1:0] == $past(wr_data_i[STORE_W-1:0]));
  p_top_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:STORE_W] == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
  import adc_trig_pkg::*;
#(
  parameter int NSRC = N_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NSRC-1:0]  flags_i,
  input  logic             fr_switch_i,
  input  logic             gate_i,
  output logic             start_o
);
  logic trig, prev_q;

  always_comb begin
    trig = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_i == SEL_W'(i)) trig = flags_i[i];
  end

  // forced high on a switch to free running so the switch cannot look like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= fr_switch_i ? 1'b1 : trig;
  end

  assign start_o = gate_i && trig && !prev_q;

  p_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_fr_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_switch_i |=> !start_o);
  p_unused_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i >= SEL_W'(NSRC)) |-> !start_o);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              left_adj_o,
  input  logic              conv_done_i,
  input  logic              cmp_flag_i,
  input  logic              ext0_flag_i,
  input  logic              tc0_cmpa_flag_i,
  input  logic              tc0_ovf_flag_i,
  input  logic              auto_en_i,
  input  logic              adc_en_i,
  output logic              start_o
);
  logic [SEL_W-1:0] sel;
  logic             fr_switch;
  logic [N_SRC-1:0] flags;

  // indexed by select code
  assign flags = {tc0_ovf_flag_i, tc0_cmpa_flag_i, ext0_flag_i, cmp_flag_i, conv_done_i};

  adc_trig_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .sel_o(sel), .left_adj_o, .fr_switch_o(fr_switch)
  );

  adc_trig_edge #(.NSRC(N_SRC)) u_edge (
    .clk_i, .rst_ni, .sel_i(sel), .flags_i(flags),
    .fr_switch_i(fr_switch), .gate_i(auto_en_i && adc_en_i), .start_o
  );

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (auto_en_i && adc_en_i));
  p_ladj_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> left_adj_o == $past(wr_data_i[LADJ_B]));
endmodule

// File: tb/adc_trig_sel_bench.sv
module adc_trig_sel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, done = 0, cmp = 0, ext0 = 0, cmpa = 0, ovf = 0, aen = 0, en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic ladj, start;
  int total = 0, bad = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  adc_trig_sel u_adc_trig_sel (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .left_adj_o(ladj), .conv_done_i(done), .cmp_flag_i(cmp),
    .ext0_flag_i(ext0), .tc0_cmpa_flag_i(cmpa), .tc0_ovf_flag_i(ovf),
    .auto_en_i(aen), .adc_en_i(en), .start_o(start)
  );

  // reference model
  int m_reg = 0;
  bit m_prev = 1;

  function automatic bit m_trig();
    case (m_reg & 7)
      0: return done;
      1: return cmp;
      2: return ext0;
      3: return cmpa;
      4: return ovf;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) if (rst_n) begin
    if (wr_en && (wr_data[2:0] == 0) && ((m_reg & 7) != 0)) m_prev = 1;
    else m_prev = m_trig();
    if (wr_en) m_reg = wr_data & 8'h3F;
  end

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({tag, " start"}, start, aen & en & m_trig() & ~m_prev);
    chk("R2 read", rd_data, m_reg);
    chk("R3 align", ladj, (m_reg >> 4) & 1);
  end

  int pulses = 0;
  always @(negedge clk) if (rst_n && start) pulses++;

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic clr();
    {done, cmp, ext0, cmpa, ovf} = '0; cyc(2);
  endtask

  initial begin
    fork
      begin #3ms; bad++; total++; $display("FAIL watchdog"); $display("  test done: total=%0d bad=%0d", total, bad); $finish; end
    join_none
    cyc(3);
    tag = "R1";
    chk("R1 read", rd_data, 0); chk("R1 align", ladj, 0); chk("R1 start", start, 0);
    rst_n = 1; cyc(2);
    chk("R1 read after", rd_data, 0);
    aen = 1; en = 1;
    // R2 / R3: upper bits dropped, spare bits kept
    tag = "R2"; wr(8'hFF); cyc(); chk("R2 spare", rd_data, 8'h3F); chk("R3 ladj set", ladj, 1);
    wr(8'hC0); chk("R2 clear", rd_data, 0); chk("R3 ladj clr", ladj, 0);
    wr(8'h28); chk("R2 spare bits", rd_data, 8'h28);
    // R10: codes 5..7
    tag = "R10";
    for (int c = 5; c < 8; c++) begin
      wr(8'(c)); pulses = 0;
      {done, cmp, ext0, cmpa, ovf} = '1; cyc(2); clr();
      chk("R10 no pulse", pulses, 0);
    end
    // R4 / R6: each source, only its own flag fires
    tag = "R4";
    for (int s = 1; s < 5; s++) begin
      wr(8'(s)); cyc();
      for (int f = 0; f < 5; f++) begin
        pulses = 0;
        case (f) 0: done = 1; 1: cmp = 1; 2: ext0 = 1; 3: cmpa = 1; default: ovf = 1; endcase
        cyc(3); clr();
        chk(f == s ? "R6 one pulse" : "R4 other flag", pulses, f == s ? 1 : 0);
      end
    end
    // R5: gating
    tag = "R5"; wr(8'h01); cyc();
    aen = 0; pulses = 0; cmp = 1; cyc(2); clr(); chk("R5 auto off", pulses, 0);
    aen = 1; en = 0; cmp = 1; cyc(2); clr(); chk("R5 adc off", pulses, 0);
    en = 1;
    // R7: switch low source -> high source
    tag = "R7"; ext0 = 1; cyc(2); pulses = 0;
    wr(8'h02); chk("R7 switch pulse", start, 1); cyc(); clr();
    // R8: switch into free running with done high (prev source low)
    tag = "R8"; wr(8'h02); done = 1; cyc(2); pulses = 0;
    wr(8'h00); chk("R8 quiet", start, 0); cyc(2);
    chk("R8 no pulse", pulses, 0);
    // R8 with write and rising done in the same cycle
    wr(8'h03); done = 0; cyc(2);
    done = 1; wr(8'h00); chk("R8 same cycle", start, 0); cyc();
    // R9: free running retrigger
    tag = "R9"; pulses = 0;
    done = 0; cyc(); done = 1; cyc(); done = 0; cyc(); done = 1; cyc(2);
    chk("R9 two pulses", pulses, 2);
    // mixed: write while old flag rises
    tag = "R7"; clr(); wr(8'h01);
    cmp = 1; ext0 = 1; wr(8'h02); cyc(2); clr();
    // R3 while converting
    tag = "R3"; wr(8'h10); chk("R3 live", ladj, 1);
    cyc(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule